// File: doc/BRIEF.md
# Sequential Single-Precision Floating-Point Divider

This block divides one 32-bit binary floating-point number by another. Each operand is a sign bit, an 8-bit exponent with bias 127 and a 23-bit fraction that has a hidden leading one. A caller presents both operands with a one-cycle `start` pulse. The block captures them, resolves zero operands at once, and otherwise runs a restoring division of the significands. That division produces one quotient bit per clock. The block then normalises the quotient, checks the exponent range and presents the quotient with a one-cycle `done` pulse. Four flags report the outcome: divide-by-zero, invalid (zero over zero), overflow and underflow.

The significand division behaves as if the dividend significand were widened to 48 bits by appending 24 zeros and then divided by the 24-bit divisor significand. The block runs 25 compare-and-subtract steps and keeps the integer quotient. If the quotient's leading position is clear, the block takes the lower bits instead, which is a one-place left shift, and lowers the exponent by one. Bits below the kept fraction are dropped, so rounding is by truncation. Infinity, NaN and denormal inputs are outside the operand set the block accepts.

The controller is a four-state machine. `S_IDLE` waits for `start`. On `start`, a zero operand takes the transition `IDLE->DONE`, and any other pair takes `IDLE->DIV`. `S_DIV` runs one quotient step per cycle and repeats `DIV->DIV` until 25 steps are complete, then takes `DIV->NORM`. `S_NORM` normalises the quotient, checks the range and registers the result, then takes `NORM->DONE`. `S_DONE` raises `done` for one cycle and returns with `DONE->IDLE`.

Top module: `fp32_div_seq`

## Requirements
- R1: After reset, `done` and `busy` are 0, `quot` is 0x00000000 and all four flags are 0.
- R2: For finite nonzero operands, the result sign (bit 31) equals the XOR of the operand sign bits.
- R3: For finite nonzero operands, the result exponent (bits 30:23) is ea - eb + 127 when the dividend significand is at least the divisor significand, and ea - eb + 126 otherwise.
- R4: The result fraction (bits 22:0) is the truncated quotient: with q = floor(ma * 2^24 / mb), where ma and mb are the operand significands with the hidden one, the fraction is q[23:1] if q[24] is 1 and q[22:0] otherwise. No rounding up takes place; for example, 1/3 gives 0x3EAAAAAA.
- R5: A zero divisor with a nonzero dividend gives exponent 255 and fraction 0, with the XOR sign, and sets `flg_dz` only.
- R6: A zero dividend over a zero divisor gives 0x7FC00000 (exponent 255, fraction 0x400000), whatever the signs are, and sets `flg_inv` only.
- R7: A zero dividend with a nonzero divisor gives a zero with the XOR sign and no flags.
- R8: If the computed exponent is 255 or more, the result is infinity with the XOR sign and only `flg_ovf` is set. An exponent of exactly 254 passes unflagged.
- R9: If the computed exponent is 0 or less, the result is zero with the XOR sign and only `flg_unf` is set. An exponent of exactly 1 passes unflagged.
- R10: Latency is fixed. If either operand is zero, `done` rises in the first cycle after the `start` edge. Otherwise it rises in the 27th cycle, whatever the operand values, and `busy` stays high from the cycle after `start` until `done`.
- R11: A `start` pulse while `busy` is high is ignored, and the result belongs to the operands captured first.
- R12: `done` is high for exactly one cycle. `quot` and the flags hold their values after `done` until the next result is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request that captures `opa` and `opb` while idle |
| opa | input | 32 | Dividend operand |
| opb | input | 32 | Divisor operand |
| busy | output | 1 | High while a division is in progress |
| done | output | 1 | One-cycle pulse marking a valid result |
| quot | output | 32 | Quotient |
| flg_dz | output | 1 | Divide by zero |
| flg_inv | output | 1 | Invalid operation (zero over zero) |
| flg_ovf | output | 1 | Exponent overflow, result forced to infinity |
| flg_unf | output | 1 | Exponent underflow, result forced to zero |

## Verification
The assertions assume that every operand is either a normal number with an exponent from 1 to 254 or an exact zero with exponent and fraction both 0. Under that assumption, the divisor significand always has its top bit set, which keeps the partial remainder below twice the divisor. They also assume that `start` arrives as a pulse. The stimulus stays inside this set: every operand either has an exponent chosen between 1 and 254 or is written as a signed zero. No infinity, NaN or denormal pattern is ever driven, and `start` is raised for one cycle per request. The only exception is the deliberate mid-run pulse, which checks that a request arriving while `busy` is high is ignored.

// File: rtl/fpdiv_pkg.sv
package fpdiv_pkg;

    localparam int EXP_W    = 8;
    localparam int FRAC_W   = 23;
    localparam int WORD_W   = 1 + EXP_W + FRAC_W;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int Q_W      = SIG_W + 1;
    localparam int EDIFF_W  = EXP_W + 2;
    localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_TOP  = (1 << EXP_W) - 1;
    localparam int NAN_FRAC = 1 << (FRAC_W - 1);
    localparam int CNT_W    = $clog2(Q_W);

    typedef enum logic [1:0] {
        S_IDLE,
        S_DIV,
        S_NORM,
        S_DONE
    } div_state_t;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [SIG_W-1:0]  sig;
        logic              zero;
    } fp_fields_t;

endpackage

// File: rtl/fpdiv_unpack.sv
module fpdiv_unpack
    import fpdiv_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output fp_fields_t        fld
);

    logic exp_nz;

    always_comb begin
        exp_nz   = |word[WORD_W-2 -: EXP_W];
        fld.sign = word[WORD_W-1];
        fld.exp  = word[WORD_W-2 -: EXP_W];
        fld.sig  = {exp_nz, word[FRAC_W-1:0]};
        fld.zero = ~exp_nz;
    end

endmodule

// File: rtl/fpdiv_sig_core.sv
module fpdiv_sig_core #(
    parameter int SIG_W = 24,
    parameter int Q_W   = 25
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [SIG_W-1:0] dvd,
    input  logic [SIG_W-1:0] dvs,
    output logic [Q_W-1:0]   quo
);

    localparam int R_W = SIG_W + 1;

    logic [R_W-1:0] rem;
    logic [R_W:0]   trial;
    logic           fits;
    logic [R_W-1:0] rem_sel;

    always_comb begin
        trial   = {1'b0, rem} - {2'b00, dvs};
        fits    = ~trial[R_W];
        rem_sel = fits ? trial[R_W-1:0] : rem;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem <= '0;
            quo <= '0;
        end else if (load) begin
            rem <= {1'b0, dvd};
            quo <= '0;
        end else if (step) begin
            rem <= rem_sel << 1;
            quo <= {quo[Q_W-2:0], fits};
        end
    end

    // R4: the partial remainder stays below twice the divisor after each step
    p_rem_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (load || step) |=> (rem < {dvs, 1'b0}));

endmodule

// File: rtl/fpdiv_pack.sv
module fpdiv_pack
    import fpdiv_pkg::*;
(
    input  logic                      sign,
    input  logic signed [EDIFF_W-1:0] ediff,
    input  logic [Q_W-1:0]            quo,
    output logic [WORD_W-1:0]         res,
    output logic                      ovf,
    output logic                      unf
);

    localparam logic signed [EDIFF_W-1:0] BIAS_S = EDIFF_W'(BIAS);
    localparam logic signed [EDIFF_W-1:0] TOP_S  = EDIFF_W'(EXP_TOP);
    localparam logic signed [EDIFF_W-1:0] ONE_S  = EDIFF_W'(1);
    localparam logic signed [EDIFF_W-1:0] ZERO_S = '0;

    logic signed [EDIFF_W-1:0] e_fin;
    logic [FRAC_W-1:0]         frac;

    always_comb begin
        if (quo[Q_W-1]) begin
            e_fin = ediff + BIAS_S;
            frac  = quo[Q_W-2:1];
        end else begin
            e_fin = ediff + BIAS_S - ONE_S;
            frac  = quo[Q_W-3:0];
        end
        ovf = 1'b0;
        unf = 1'b0;
        if (e_fin >= TOP_S) begin
            ovf = 1'b1;
            res = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (e_fin <= ZERO_S) begin
            unf = 1'b1;
            res = {sign, {(WORD_W-1){1'b0}}};
        end else begin
            res = {sign, e_fin[EXP_W-1:0], frac};
        end
    end

endmodule

// File: rtl/fp32_div_seq.sv
module fp32_div_seq
    import fpdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] opa,
    input  logic [WORD_W-1:0] opb,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] quot,
    output logic              flg_dz,
    output logic              flg_inv,
    output logic              flg_ovf,
    output logic              flg_unf
);

    localparam logic [WORD_W-1:0] NAN_WORD =
        {1'b0, {EXP_W{1'b1}}, FRAC_W'(NAN_FRAC)};
    localparam logic [CNT_W-1:0]  LAST_STEP = CNT_W'(Q_W - 1);

    div_state_t state, state_nx;

    fp_fields_t fa, fb;
    logic                      a_sign, b_sign;
    logic [EXP_W-1:0]          a_exp, b_exp;
    logic [SIG_W-1:0]          b_sig;
    logic [CNT_W-1:0]          cnt;
    logic                      any_zero;
    logic                      load, step;
    logic [Q_W-1:0]            quo;
    logic signed [EDIFF_W-1:0] ediff;
    logic [WORD_W-1:0]         pk_res;
    logic                      pk_ovf, pk_unf;

    fpdiv_unpack u_unpack_a (.word(opa), .fld(fa));
    fpdiv_unpack u_unpack_b (.word(opb), .fld(fb));

    assign any_zero = fa.zero | fb.zero;
    assign load     = (state == S_IDLE) && start && !any_zero;
    assign step     = (state == S_DIV);
    assign ediff    = EDIFF_W'(a_exp) - EDIFF_W'(b_exp);

    fpdiv_sig_core #(.SIG_W(SIG_W), .Q_W(Q_W)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .dvd   (fa.sig),
        .dvs   (b_sig),
        .quo   (quo)
    );

    fpdiv_pack u_pack (
        .sign  (a_sign ^ b_sign),
        .ediff (ediff),
        .quo   (quo),
        .res   (pk_res),
        .ovf   (pk_ovf),
        .unf   (pk_unf)
    );

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: if (start) state_nx = any_zero ? S_DONE : S_DIV;
            S_DIV:  if (cnt == LAST_STEP) state_nx = S_NORM;
            S_NORM: state_nx = S_DONE;
            S_DONE: state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_sign  <= 1'b0;
            b_sign  <= 1'b0;
            a_exp   <= '0;
            b_exp   <= '0;
            b_sig   <= '0;
            cnt     <= '0;
            quot    <= '0;
            flg_dz  <= 1'b0;
            flg_inv <= 1'b0;
            flg_ovf <= 1'b0;
            flg_unf <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        a_sign <= fa.sign;
                        b_sign <= fb.sign;
                        a_exp  <= fa.exp;
                        b_exp  <= fb.exp;
                        b_sig  <= fb.sig;
                        cnt    <= '0;
                        if (any_zero) begin
                            flg_ovf <= 1'b0;
                            flg_unf <= 1'b0;
                            flg_inv <= fa.zero & fb.zero;
                            flg_dz  <= ~fa.zero & fb.zero;
                            if (fa.zero && fb.zero)
                                quot <= NAN_WORD;
                            else if (fb.zero)
                                quot <= {fa.sign ^ fb.sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
                            else
                                quot <= {fa.sign ^ fb.sign, {(WORD_W-1){1'b0}}};
                        end
                    end
                end
                S_DIV: cnt <= cnt + 1'b1;
                S_NORM: begin
                    quot    <= pk_res;
                    flg_ovf <= pk_ovf;
                    flg_unf <= pk_unf;
                    flg_dz  <= 1'b0;
                    flg_inv <= 1'b0;
                end
                S_DONE: ;
                default: ;
            endcase
        end
    end

    assign busy = (state != S_IDLE);
    assign done = (state == S_DONE);

    // R12: done lasts a single cycle
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12: result held once done has dropped, until a new start
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> $stable(quot));

    // R6: at most one flag reported with a result
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0({flg_dz, flg_inv, flg_ovf, flg_unf}));

    // R6: invalid result is the fixed NaN word
    p_nan_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flg_inv) |-> (quot == NAN_WORD));

    // R8: overflow is reported as infinity
    p_ovf_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flg_ovf) |-> (quot[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}));

    // R9: underflow is reported as zero
    p_unf_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flg_unf) |-> (quot[WORD_W-2:0] == '0));

    // R10: step counter never runs past the last quotient bit
    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DIV) |-> (cnt <= LAST_STEP));

    // R11: captured operands untouched while busy
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(a_exp) && $stable(b_exp) && $stable(b_sig)));

endmodule

// File: tb/test_fp32_div_seq.sv
`timescale 1ns/1ps
module test_fp32_div_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] opa = '0, opb = '0;
    logic        busy, done, flg_dz, flg_inv, flg_ovf, flg_unf;
    logic [31:0] quot;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fp32_div_seq i_fp32_div_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opa(opa), .opb(opb),
        .busy(busy), .done(done), .quot(quot),
        .flg_dz(flg_dz), .flg_inv(flg_inv), .flg_ovf(flg_ovf), .flg_unf(flg_unf)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected {dz, inv, ovf, unf, word} from the requirements
    function automatic logic [35:0] model(input logic [31:0] a, input logic [31:0] b);
        logic        s;
        int          ea, eb, e;
        longint      ma, mb, q;
        logic [22:0] fr;
        s  = a[31] ^ b[31];
        ea = int'(a[30:23]);
        eb = int'(b[30:23]);
        if (ea == 0 && eb == 0) return {4'b0100, 32'h7FC00000};
        if (eb == 0) return {4'b1000, s, 8'hFF, 23'h0};
        if (ea == 0) return {4'b0000, s, 31'h0};
        ma = longint'({1'b1, a[22:0]});
        mb = longint'({1'b1, b[22:0]});
        q  = (ma * 64'd16777216) / mb;
        e  = ea - eb + 127;
        if (q >= 64'd16777216) fr = 23'((q >> 1) & 64'h7FFFFF);
        else begin
            fr = 23'(q & 64'h7FFFFF);
            e  = e - 1;
        end
        if (e >= 255) return {4'b0010, s, 8'hFF, 23'h0};
        if (e <= 0)   return {4'b0001, s, 31'h0};
        return {4'b0000, s, 8'(e), fr};
    endfunction

    task automatic run_op(input logic [31:0] a, input logic [31:0] b, output int lat);
        @(negedge clk);
        opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_op(input logic [31:0] a, input logic [31:0] b, input string tag, input int exp_lat);
        int lat;
        logic [35:0] m;
        m = model(a, b);
        run_op(a, b, lat);
        chk(quot == m[31:0], tag, 64'(quot), 64'(m[31:0]));
        chk({flg_dz, flg_inv, flg_ovf, flg_unf} == m[35:32], {tag, " flags"},
            64'({flg_dz, flg_inv, flg_ovf, flg_unf}), 64'(m[35:32]));
        chk(lat == exp_lat, "R10 latency", 64'(lat), 64'(exp_lat));
    endtask

    task automatic t_reset;
        chk(done == 1'b0 && busy == 1'b0, "R1 done/busy", 64'({done, busy}), 64'd0);
        chk(quot == 32'h0, "R1 quot", 64'(quot), 64'd0);
        chk({flg_dz, flg_inv, flg_ovf, flg_unf} == 4'b0, "R1 flags",
            64'({flg_dz, flg_inv, flg_ovf, flg_unf}), 64'd0);
    endtask

    task automatic t_known;
        int lat;
        run_op(32'h40C00000, 32'h40400000, lat);   // 6 / 3
        chk(quot == 32'h40000000, "R3 6/3", 64'(quot), 64'h40000000);
        run_op(32'hC1900000, 32'h41180000, lat);   // -18 / 9.5
        chk(quot[31] == 1'b1, "R2 sign", 64'(quot[31]), 64'd1);
        run_op(32'h3F800000, 32'h40400000, lat);   // 1 / 3 truncated
        chk(quot == 32'h3EAAAAAA, "R4 1/3", 64'(quot), 64'h3EAAAAAA);
        run_op(32'hBF800000, 32'hC0400000, lat);   // -1 / -3
        chk(quot == 32'h3EAAAAAA, "R2 neg/neg", 64'(quot), 64'h3EAAAAAA);
    endtask

    task automatic t_sweep;
        logic [31:0] lf = 32'hACE1_2357;
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = lf * 32'd1664525 + 32'd1013904223;
            a = {lf[31], 1'b0, 1'b1, lf[5:0], lf[28:6]};
            lf = lf * 32'd1664525 + 32'd1013904223;
            b = {lf[30], 1'b0, 1'b1, lf[11:6], lf[27:5]};
            check_op(a, b, "R2 R3 R4 sweep", 27);
        end
    endtask

    task automatic t_specials;
        check_op(32'h40A00000, 32'h00000000, "R5 x/0", 1);
        check_op(32'hC0A00000, 32'h00000000, "R5 -x/0", 1);
        chk(quot == 32'hFF800000, "R5 neg inf", 64'(quot), 64'hFF800000);
        check_op(32'h00000000, 32'h80000000, "R6 0/-0", 1);
        chk(quot == 32'h7FC00000, "R6 nan", 64'(quot), 64'h7FC00000);
        check_op(32'h00000000, 32'hC0400000, "R7 0/-3", 1);
        chk(quot == 32'h80000000, "R7 signed zero", 64'(quot), 64'h80000000);
    endtask

    task automatic t_range;
        check_op(32'h7F000000, 32'h3F800000, "R8 exp 254 ok", 27);
        chk(flg_ovf == 1'b0, "R8 no ovf at 254", 64'(flg_ovf), 64'd0);
        check_op(32'h7F000000, 32'h3F000000, "R8 exp 255 ovf", 27);
        chk(flg_ovf == 1'b1, "R8 ovf flag", 64'(flg_ovf), 64'd1);
        check_op(32'hF1800000, 32'h0D800000, "R8 large ovf", 27);
        check_op(32'h00800000, 32'h3F800000, "R9 exp 1 ok", 27);
        chk(quot == 32'h00800000, "R9 min normal", 64'(quot), 64'h00800000);
        check_op(32'h80800000, 32'h40000000, "R9 exp 0 unf", 27);
        chk(quot == 32'h80000000 && flg_unf, "R9 unf zero", 64'(quot), 64'h80000000);
        check_op(32'h00800000, 32'h3FC00000, "R9 norm shift unf", 27);
    endtask

    task automatic t_busy_ignore;
        int lat;
        logic [35:0] m;
        m = model(32'h41200000, 32'h40800000);
        @(negedge clk);
        opa = 32'h41200000; opb = 32'h40800000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        repeat (4) begin @(negedge clk); lat++; end
        chk(busy == 1'b1, "R10 busy during run", 64'(busy), 64'd1);
        opa = 32'h3F800000; opb = 32'h00000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat++;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == 27, "R11 latency unchanged", 64'(lat), 64'd27);
        chk(quot == m[31:0], "R11 first operands kept", 64'(quot), 64'(m[31:0]));
        chk(flg_dz == 1'b0, "R11 no dz", 64'(flg_dz), 64'd0);
    endtask

    task automatic t_done_hold;
        int lat;
        logic [31:0] held;
        run_op(32'h40C00000, 32'h40400000, lat);
        held = quot;
        @(negedge clk);
        chk(done == 1'b0, "R12 done one cycle", 64'(done), 64'd0);
        chk(busy == 1'b0, "R12 idle after done", 64'(busy), 64'd0);
        repeat (3) @(negedge clk);
        chk(quot == held, "R12 quot held", 64'(quot), 64'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_known();
        t_sweep();
        t_specials();
        t_range();
        t_busy_ignore();
        t_done_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule